// File: doc/BRIEF.md
# Strap-Configured Dual-Protocol Host Bus Slave

This block is the host-facing register port of a decoder-style peripheral. An external controller reaches a small set of registers through a 4-bit address under an active-low select. It writes code bytes into an internal queue, sets an interrupt enable mask, reads and clears a pending-event register, and uses a scratch word. Three strap pins fix the data width (8 or 16 bits), the byte lane order in 16-bit mode and the handshake style. They are sampled only while reset is held low. Later changes on these pins have no effect until the next reset.

Two handshakes are supported on the same two control pins. In Type A, `ctl_a` gives the direction and `ctl_b` is an active-low data strobe. In Type B, `ctl_a` is an active-low write strobe and `ctl_b` is an active-low read strobe. The control pins pass through a two-flop synchroniser before any decision is made.

The block drives three outputs toward the host:
- an acknowledge/wait pin, whose meaning depends on the handshake style;
- a ready flag, which tells the host how much code it may burst into the queue;
- an active-low interrupt request.

Each pin that would be tri-stated on a board has its own output-enable signal.

Top module: `host_bus_slave`

## Requirements
- R1: The straps `strap_wide`, `strap_swap` and `strap_typeb` are sampled on every clock while `rst_n` is low. The value present at the last reset clock is kept until the next reset, and pin changes after reset have no effect.
- R2: Type A (`strap_typeb`=0) works as follows. `ctl_b` low with `cs_n` low marks an access, and `ctl_a` high means read while low means write. A read latches its data on the third rising clock edge after the strobe is driven low. A write takes `din` when the strobe or select is released.
- R3: Type B (`strap_typeb`=1) works as follows. `ctl_a` low with `cs_n` low is a write, and `ctl_b` low with `cs_n` low is a read. The same latching rules as R2 apply.
- R4: In 16-bit mode with `strap_swap`=0, the bus word is the register word. With `strap_swap`=1, the two bytes are exchanged for both writes and reads.
- R5: In 8-bit mode (`strap_wide`=0), only `din[7:0]` is used, `dout[15:8]` reads as zero, and the scratch register keeps 8 bits.
- R6: The register map is as follows:
  - Address 0 is the code port. A write pushes the low byte of the register word.
  - Address 1 is the interrupt mask. Bit i enables event i.
  - Address 2 is the pending-event status. Reading it returns the pending bits and clears them.
  - Address 3 is a 16-bit scratch register.
  - Any other address reads as zero.
- R7: In Type A, `ack_n` is low from the latching edge until the strobe is released. In Type B, `ack_n` is a wait pulse: it is low for WAIT_CYC cycles from the latching edge and then high, even while the strobe is still held.
- R8: `ack_oe` and `irq_oe` are high whenever their active-low pin is low, and for one further cycle after that pin returns high.
- R9: A one-cycle pulse on `evt[i]` sets pending bit i. `irq_n` is low while any pending bit has its mask bit set. Reading the status register, clearing the mask bit, or reset releases it. An event that arrives in the same cycle as a status read stays pending.
- R10: The code queue holds BURST+2 bytes and delivers them in order on `code_data`/`code_valid`/`code_pop`. `rdy` is high while more than two entries are free. Writes to a full queue are dropped.
- R11: `dout_oe` is high during a read access, from the latching edge until the strobe is released, and low at all other times.
- R12: After reset, `rdy` is 1, `ack_n` and `irq_n` are 1, all three output enables are 0, and `code_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps sampled while low |
| strap_wide | input | 1 | 0: 8-bit bus, 1: 16-bit bus |
| strap_swap | input | 1 | 16-bit byte order: 1 exchanges the bytes |
| strap_typeb | input | 1 | 0: Type A handshake, 1: Type B |
| cs_n | input | 1 | Active-low select |
| addr | input | 4 | Register address |
| ctl_a | input | 1 | Type A: read/write direction; Type B: write strobe (low) |
| ctl_b | input | 1 | Type A: data strobe (low); Type B: read strobe (low) |
| din | input | 16 | Write data from host |
| dout | output | 16 | Read data to host |
| dout_oe | output | 1 | Output enable for the data pins |
| ack_n | output | 1 | Acknowledge (Type A) or wait (Type B), active low |
| ack_oe | output | 1 | Output enable for ack_n |
| irq_n | output | 1 | Interrupt request, active low |
| irq_oe | output | 1 | Output enable for irq_n |
| rdy | output | 1 | Code burst ready flag |
| evt | input | NEV | Event pulses from the core |
| code_pop | input | 1 | Core consumes the head byte |
| code_data | output | 8 | Head byte of the code queue |
| code_valid | output | 1 | Code queue not empty |

## Verification
A status read clearing the pending register and a new event setting a pending bit can land on the same clock edge. The bench provokes this by raising an event exactly on the latching edge of a status read; it counts the synchroniser stages from the strobe edge to find that edge. The test passes only if three things hold: the read returns the old pending value, the interrupt stays asserted, and a second status read returns the new event.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    typedef struct packed {
        logic wide;
        logic swap;
        logic typeb;
    } cfg_t;

    localparam logic [3:0] REG_CODE = 4'd0;
    localparam logic [3:0] REG_MASK = 4'd1;
    localparam logic [3:0] REG_STAT = 4'd2;
    localparam logic [3:0] REG_SCR  = 4'd3;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '1;
            s2_q <= '1;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/hbs_code_fifo.sv
module hbs_code_fifo #(
    parameter int BURST = 4,
    localparam int DEPTH = BURST + 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    wdata,
    input  logic          pop,
    output logic [7:0]    head,
    output logic          valid,
    output logic          ready,
    output logic [CW-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fs_t;

    fs_t q, d;
    logic [7:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        d = q;
        if (do_push) d.wp = step(q.wp);
        if (do_pop)  d.rp = step(q.rp);
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    assign head  = mem[q.rp];
    assign valid = (q.cnt != '0);
    assign ready = (CW'(DEPTH) - q.cnt) > CW'(2);
    assign level = q.cnt;
endmodule

// File: rtl/host_bus_slave.sv
module host_bus_slave #(
    parameter int NEV      = 4,
    parameter int BURST    = 4,
    parameter int WAIT_CYC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strap_wide,
    input  logic           strap_swap,
    input  logic           strap_typeb,
    input  logic           cs_n,
    input  logic [3:0]     addr,
    input  logic           ctl_a,
    input  logic           ctl_b,
    input  logic [15:0]    din,
    output logic [15:0]    dout,
    output logic           dout_oe,
    output logic           ack_n,
    output logic           ack_oe,
    output logic           irq_n,
    output logic           irq_oe,
    output logic           rdy,
    input  logic [NEV-1:0] evt,
    input  logic           code_pop,
    output logic [7:0]     code_data,
    output logic           code_valid
);
    import hbs_pkg::*;

    localparam int DEPTH = BURST + 2;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int WC_W  = $clog2(WAIT_CYC + 1);

    typedef struct packed {
        cfg_t            cfg;
        logic            act_prev;
        logic            is_wr;
        logic [3:0]      aa;
        logic            rd_oe;
        logic            ack_act;
        logic            ack_hold;
        logic [WC_W-1:0] wcnt;
        logic [NEV-1:0]  pend;
        logic [NEV-1:0]  mask;
        logic            irq_hold;
        logic [15:0]     scr;
        logic [15:0]     dout;
    } st_t;

    st_t q, d;

    logic [2:0]    sync_out;
    logic          cs_s, ca_s, cb_s;
    logic          act, rd, start, fin, irq_act;
    logic [15:0]   word_in, rdata;
    logic          push;
    logic [CW-1:0] fifo_level;
    cfg_t          cur_cfg;

    hbs_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, ctl_a, ctl_b}),
        .q     (sync_out)
    );
    assign {cs_s, ca_s, cb_s} = sync_out;

    function automatic logic [15:0] lane_map(input cfg_t c, input logic [15:0] w);
        if (!c.wide)     return {8'h00, w[7:0]};
        else if (c.swap) return {w[7:0], w[15:8]};
        else             return w;
    endfunction

    always_comb begin
        act     = !cs_s && (q.cfg.typeb ? (!ca_s || !cb_s) : !cb_s);
        rd      = q.cfg.typeb ? !cb_s : ca_s;
        start   = act && !q.act_prev;
        fin     = !act && q.act_prev;
        word_in = lane_map(q.cfg, din);
        irq_act = |(q.pend & q.mask);
        push    = fin && q.is_wr && (q.aa == REG_CODE);

        case (addr)
            REG_MASK: rdata = 16'(q.mask);
            REG_STAT: rdata = 16'(q.pend);
            REG_SCR:  rdata = q.scr;
            default:  rdata = '0;
        endcase

        d          = q;
        d.act_prev = act;
        d.ack_hold = q.ack_act;
        d.irq_hold = irq_act;
        d.pend     = q.pend | evt;

        if (start) begin
            d.aa    = addr;
            d.is_wr = !rd;
            d.rd_oe = rd;
            if (rd) begin
                d.dout = lane_map(q.cfg, rdata);
                if (addr == REG_STAT) d.pend = evt;
            end
            d.ack_act = 1'b1;
            d.wcnt    = WC_W'(WAIT_CYC - 1);
        end else if (fin) begin
            d.rd_oe   = 1'b0;
            d.ack_act = 1'b0;
            if (q.is_wr) begin
                case (q.aa)
                    REG_MASK: d.mask = word_in[NEV-1:0];
                    REG_SCR:  d.scr  = word_in;
                    default:  ;
                endcase
            end
        end else if (q.cfg.typeb && q.ack_act) begin
            if (q.wcnt == '0) d.ack_act = 1'b0;
            else              d.wcnt = q.wcnt - WC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.cfg <= '{wide: strap_wide, swap: strap_swap, typeb: strap_typeb};
        end else begin
            q <= d;
        end
    end

    hbs_code_fifo #(.BURST(BURST)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (word_in[7:0]),
        .pop   (code_pop),
        .head  (code_data),
        .valid (code_valid),
        .ready (rdy),
        .level (fifo_level)
    );

    assign cur_cfg = q.cfg;
    assign dout    = q.dout;
    assign dout_oe = q.rd_oe;
    assign ack_n   = !q.ack_act;
    assign ack_oe  = q.ack_act || q.ack_hold;
    assign irq_n   = !irq_act;
    assign irq_oe  = irq_act || q.irq_hold;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
    parameter int DEPTH = 6,
    parameter int BURST = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input hbs_pkg::cfg_t cfg,
    input logic          ack_n,
    input logic          ack_oe,
    input logic          irq_n,
    input logic          irq_oe,
    input logic          rdy,
    input logic [15:0]   dout,
    input logic          dout_oe,
    input logic [CW-1:0] level
);
    p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg));

    p_ack_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n) |-> ack_oe);

    p_irq_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> irq_oe);

    p_low_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n |-> ack_oe) and (!irq_n |-> irq_oe));

    p_byte_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.wide && dout_oe) |-> (dout[15:8] == 8'h00));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    p_rdy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> (level == CW'(BURST)));
endmodule

bind host_bus_slave hbs_checker #(.DEPTH(DEPTH), .BURST(BURST), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     (cur_cfg),
    .ack_n   (ack_n),
    .ack_oe  (ack_oe),
    .irq_n   (irq_n),
    .irq_oe  (irq_oe),
    .rdy     (rdy),
    .dout    (dout),
    .dout_oe (dout_oe),
    .level   (fifo_level)
);

// File: tb/host_bus_slave_tb.sv
module host_bus_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_wide = 1'b1, strap_swap = 1'b0, strap_typeb = 1'b0;
    logic        cs_n = 1'b1, ctl_a = 1'b1, ctl_b = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_oe, ack_n, ack_oe, irq_n, irq_oe, rdy;
    logic [3:0]  evt = '0;
    logic        code_pop = 1'b0;
    logic [7:0]  code_data;
    logic        code_valid;

    int  total = 0, bad = 0;
    bit  tb_typeb = 1'b0;
    bit  done = 1'b0;

    logic [15:0] r_data;
    bit          r_saw_ack, r_end_ack_n, r_end_doe;

    always #2 clk = ~clk;

    host_bus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide), .strap_swap(strap_swap),
        .strap_typeb(strap_typeb), .cs_n(cs_n), .addr(addr), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .din(din), .dout(dout), .dout_oe(dout_oe), .ack_n(ack_n), .ack_oe(ack_oe),
        .irq_n(irq_n), .irq_oe(irq_oe), .rdy(rdy), .evt(evt), .code_pop(code_pop),
        .code_data(code_data), .code_valid(code_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit w, input bit s, input bit b);
        @(negedge clk);
        rst_n = 1'b0;
        strap_wide = w; strap_swap = s; strap_typeb = b;
        tb_typeb = b;
        cs_n = 1'b1; ctl_a = 1'b1; ctl_b = 1'b1; evt = '0; code_pop = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: strap pins flipped after reset must not matter
        strap_wide = ~w; strap_swap = ~s; strap_typeb = ~b;
        repeat (2) @(negedge clk);
    endtask

    task automatic access(input bit wr, input logic [3:0] a, input logic [15:0] wd, input int inj);
        @(negedge clk);
        cs_n = 1'b0; addr = a; din = wd;
        if (!tb_typeb) begin ctl_a = !wr; ctl_b = 1'b0; end
        else if (wr)   ctl_a = 1'b0;
        else           ctl_b = 1'b0;
        r_saw_ack = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!ack_n) r_saw_ack = 1'b1;
            if (i == 1 && inj >= 0) evt = 4'(1 << inj);
            if (i == 2) evt = '0;
        end
        r_data = dout; r_end_ack_n = ack_n; r_end_doe = dout_oe;
        ctl_a = 1'b1; ctl_b = 1'b1; cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_evt(input int idx);
        @(negedge clk); evt = 4'(1 << idx);
        @(negedge clk); evt = '0;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        do_reset(1, 0, 0);
        chk(rdy == 1'b1 && ack_n && irq_n, "R12 idle pins", {rdy, ack_n, irq_n}, 3'b111);
        chk(!ack_oe && !irq_oe && !dout_oe && !code_valid, "R12 enables",
            {ack_oe, irq_oe, dout_oe, code_valid}, 4'b0000);
    endtask

    task automatic t_type_a_wide;
        do_reset(1, 0, 0);
        access(1, 4'd3, 16'h1234, -1);
        chk(r_saw_ack && !r_end_ack_n, "R7 type A ack held", {r_saw_ack, r_end_ack_n}, 2'b10);
        chk(!ack_oe, "R8 ack_oe released", ack_oe, 0);
        access(0, 4'd3, 16'h0000, -1);
        chk(r_data == 16'h1234, "R2 scratch read", r_data, 16'h1234);
        chk(r_end_doe == 1'b1, "R11 dout_oe during read", r_end_doe, 1);
        chk(dout_oe == 1'b0, "R11 dout_oe after read", dout_oe, 0);
        access(0, 4'd9, 16'h0000, -1);
        chk(r_data == 16'h0000, "R6 unmapped reads zero", r_data, 0);
    endtask

    task automatic t_swap;
        do_reset(1, 1, 0);
        access(1, 4'd0, 16'h5A00, -1);
        chk(code_valid && code_data == 8'h5A, "R4 swapped code byte", code_data, 8'h5A);
        access(1, 4'd1, 16'h0300, -1);
        access(0, 4'd1, 16'h0000, -1);
        chk(r_data == 16'h0300, "R4 swapped mask read", r_data, 16'h0300);
    endtask

    task automatic t_narrow;
        do_reset(0, 0, 0);
        access(1, 4'd3, 16'hFF77, -1);
        access(0, 4'd3, 16'h0000, -1);
        chk(r_data == 16'h0077, "R5 narrow scratch", r_data, 16'h0077);
    endtask

    task automatic t_type_b;
        do_reset(1, 0, 1);
        access(1, 4'd3, 16'hA5C3, -1);
        access(0, 4'd3, 16'h0000, -1);
        chk(r_data == 16'hA5C3, "R3 type B round trip (R1 pins flipped)", r_data, 16'hA5C3);
        chk(r_saw_ack && r_end_ack_n, "R7 type B wait pulse", {r_saw_ack, r_end_ack_n}, 2'b11);
    endtask

    task automatic t_irq;
        bit prev_n, seen;
        do_reset(1, 0, 0);
        pulse_evt(0);
        chk(irq_n == 1'b1, "R9 masked event silent", irq_n, 1);
        access(1, 4'd1, 16'h0001, -1);
        chk(irq_n == 1'b0 && irq_oe, "R9 enabled irq", {irq_n, irq_oe}, 2'b01);
        access(0, 4'd2, 16'h0000, -1);
        chk(r_data == 16'h0001, "R6 status read", r_data, 16'h0001);
        chk(irq_n == 1'b1 && !irq_oe, "R9 cleared by status read", {irq_n, irq_oe}, 2'b10);
        pulse_evt(0);
        chk(irq_n == 1'b0, "R9 re-raised", irq_n, 0);
        prev_n = 1'b0; seen = 1'b0;
        fork
            access(1, 4'd1, 16'h0000, -1);
            for (int i = 0; i < 14; i++) begin
                @(negedge clk);
                if (!seen && !prev_n && irq_n) begin
                    seen = 1'b1;
                    chk(irq_oe == 1'b1, "R8 irq_oe held one cycle", irq_oe, 1);
                    @(negedge clk);
                    chk(irq_oe == 1'b0, "R8 irq_oe then released", irq_oe, 0);
                end
                prev_n = irq_n;
            end
        join
        chk(seen && irq_n, "R9 cleared by mask", {seen, irq_n}, 2'b11);
    endtask

    task automatic t_same_cycle;
        do_reset(1, 0, 0);
        access(1, 4'd1, 16'h0003, -1);
        pulse_evt(0);
        access(0, 4'd2, 16'h0000, 1);
        chk(r_data == 16'h0001, "R9 status before collision", r_data, 16'h0001);
        chk(irq_n == 1'b0, "R9 colliding event kept", irq_n, 0);
        access(0, 4'd2, 16'h0000, -1);
        chk(r_data == 16'h0002, "R9 colliding event reported", r_data, 16'h0002);
        chk(irq_n == 1'b1, "R9 irq released", irq_n, 1);
    endtask

    task automatic t_fifo;
        do_reset(1, 0, 0);
        for (int k = 1; k <= 7; k++) begin
            access(1, 4'd0, 16'(8'h10 + k), -1);
            chk(rdy == (k < 4), "R10 ready level", rdy, (k < 4));
        end
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk(code_valid && code_data == 8'(8'h10 + k), "R10 queue order", code_data, 8'(8'h10 + k));
            code_pop = 1'b1;
            @(negedge clk);
            code_pop = 1'b0;
        end
        @(negedge clk);
        chk(code_valid == 1'b0, "R10 write to full queue dropped", code_valid, 0);
        chk(rdy == 1'b1, "R10 ready after drain", rdy, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_type_a_wide();
        t_swap();
        t_narrow();
        t_type_b();
        t_irq();
        t_same_cycle();
        t_fifo();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule